// File: doc/BRIEF.md
# Legacy INTx Message Router

This block receives in-band legacy interrupt messages from a set of downstream ports. Each message names a port, one of the four interrupt pins (INTA to INTD), and whether the pin is being raised or dropped. The router keeps one level flag per (port, pin) pair, called an entry, so that each pair behaves as a virtual level-sensitive wire between its raise and drop messages.

Each entry has a mask bit, and the mask bit decides where the entry goes. An unmasked entry is turned into an MSI write request that carries the address and data programmed for that entry. A masked entry is ORed onto a shared legacy level output for its pin, which leads toward the platform hub. Two global controls can stop that legacy forwarding: a route-disable bit, and a boot-interrupt-off bit whose value 1 means forwarding is off. When forwarding is stopped, masked interrupts simply vanish. Unmasked entries keep producing MSI writes either way.

Software programs the masks, the per-entry MSI address and data, and the two global bits through a simple write port.

Top module: `intx_router`

## Requirements
- R1: After reset every level flag is clear, every mask bit is set and both global bits are 0, so `msi_valid` and all `legacy_out` bits are 0 and legacy forwarding is active.
- R2: A message with `msg_valid`=1 sets the flag of entry `port*4+pin` when `msg_assert`=1 and clears it when `msg_assert`=0. Pin code 0 is INTA, 1 is INTB, 2 is INTC and 3 is INTD. The new flag takes effect one clock after the message.
- R3: While forwarding is active, `legacy_out[pin]` is the OR of the flags of all masked entries for that pin. It follows the flags with no extra register, and it falls only after every contributing port has dropped the pin.
- R4: While the route-disable bit (global word bit 0) is 1, every `legacy_out` bit is 0 and masked entries produce no MSI. Clearing the bit restores the outputs from the level flags that were kept.
- R5: The boot-interrupt-off bit (global word bit 1) uses inverted sense: 1 stops legacy forwarding and 0 allows it.
- R6: An unmasked entry whose flag goes from 0 to 1 produces exactly one MSI request, carrying that entry's programmed address and data. A repeated raise while the flag is already 1 produces none, and an unmasked entry never drives `legacy_out`.
- R7: Clearing the mask of an entry that is raised produces one MSI request. Setting the mask of a raised entry moves it onto `legacy_out` from the next cycle on, and also withdraws any request of that entry that has not yet reached the output.
- R8: While `msi_valid`=1 and `msi_ready`=0, `msi_valid`, `msi_addr` and `msi_data` hold their values.
- R9: Pending requests are served in ascending entry order, so the lowest entry index goes first.
- R10: Register map, where `reg_addr` = {global, entry, sub}. If global=1, the write sets the global word. If global=0, sub 0 writes the entry's mask from `reg_wdata` bit 0, sub 1 writes its MSI address, sub 2 writes its MSI data, and sub 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Interrupt message present this cycle |
| msg_port | input | PORT_W | Source downstream port |
| msg_pin | input | 2 | Pin code, 0=INTA .. 3=INTD |
| msg_assert | input | 1 | 1 raises the pin, 0 drops it |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | PORT_W+5 | {global, entry, sub} register address |
| reg_wdata | input | WORD_W | Register write data |
| msi_valid | output | 1 | MSI write request valid |
| msi_ready | input | 1 | Consumer accepts the MSI request |
| msi_addr | output | WORD_W | MSI write address |
| msi_data | output | WORD_W | MSI write data |
| legacy_out | output | 4 | Shared legacy level per pin toward the hub |

## Verification
Some properties are checked on every cycle by the assertions. The MSI output stays stable while it is stalled. The grant is one-hot and always picks the lowest pending entry. A newly armed request is never lost, and it never belongs to an entry that ends up masked. Any message lands on its own level flag. While either global control is set, no legacy line is high.

Other behaviour can only be shown by the directed scenarios in the bench. These cover the shared-line OR across ports and the exact address and data carried by each MSI. They also show that a repeated raise is suppressed, and they exercise the unmask-while-raised and mask-while-raised handovers, the cancellation of a pending request, and the ordering of several stalled requests.

// File: rtl/intx_pkg.sv
package intx_pkg;

  localparam int PINS_PER_PORT = 4;
  localparam int PIN_W         = 2;
  localparam int MAX_ENTRIES   = 64;

  typedef enum logic [1:0] {
    SUB_CTRL = 2'd0,
    SUB_ADDR = 2'd1,
    SUB_DATA = 2'd2,
    SUB_RSVD = 2'd3
  } reg_sub_e;

  // Keep only the lowest set bit of a request vector.
  function automatic logic [MAX_ENTRIES-1:0] lowest_onehot(input logic [MAX_ENTRIES-1:0] v);
    return v & (~v + 64'd1);
  endfunction

  // Index of the single set bit (0 when none is set).
  function automatic logic [5:0] onehot_index(input logic [MAX_ENTRIES-1:0] oh);
    logic [5:0] idx;
    idx = '0;
    for (int i = 0; i < MAX_ENTRIES; i++) begin
      if (oh[i]) idx = 6'(i);
    end
    return idx;
  endfunction

endpackage

// File: rtl/intx_wire_state.sv
module intx_wire_state #(
  parameter int NUM_PORTS = 4,
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int ENTRY_W  = PORT_W + intx_pkg::PIN_W,
  localparam int N        = NUM_PORTS * intx_pkg::PINS_PER_PORT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  input  logic [PORT_W-1:0] msg_port,
  input  logic [1:0]        msg_pin,
  input  logic              msg_assert,
  output logic [N-1:0]      flag_q,
  output logic [N-1:0]      flag_nxt
);

  logic [ENTRY_W-1:0] msg_idx;
  logic               msg_ok;

  assign msg_idx = {msg_port, msg_pin};
  assign msg_ok  = msg_valid && ({1'b0, msg_port} < (PORT_W+1)'(NUM_PORTS));

  always_comb begin
    flag_nxt = flag_q;
    if (msg_ok) flag_nxt[msg_idx] = msg_assert;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_nxt;
  end

  AST_FLAG_FOLLOWS_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ok |=> flag_q[$past(msg_idx)] == $past(msg_assert)); // R2

endmodule

// File: rtl/intx_cfg_regs.sv
module intx_cfg_regs #(
  parameter int NUM_PORTS = 4,
  parameter int WORD_W    = 32,
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int ENTRY_W  = PORT_W + intx_pkg::PIN_W,
  localparam int N        = NUM_PORTS * intx_pkg::PINS_PER_PORT,
  localparam int RA_W     = ENTRY_W + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [RA_W-1:0]    reg_addr,
  input  logic [WORD_W-1:0]  reg_wdata,
  input  logic [ENTRY_W-1:0] rd_idx,
  output logic [N-1:0]       mask_q,
  output logic [N-1:0]       mask_nxt,
  output logic               route_dis,
  output logic               boot_off,
  output logic [WORD_W-1:0]  rd_addr,
  output logic [WORD_W-1:0]  rd_data
);
  import intx_pkg::*;

  logic [N-1:0][WORD_W-1:0] addr_tab;
  logic [N-1:0][WORD_W-1:0] data_tab;
  logic                     wr_glob;
  logic                     wr_ent;
  logic [ENTRY_W-1:0]       wr_idx;
  reg_sub_e                 wr_sub;

  assign wr_glob = reg_wr &&  reg_addr[RA_W-1];
  assign wr_ent  = reg_wr && !reg_addr[RA_W-1];
  assign wr_idx  = reg_addr[RA_W-2:2];
  assign wr_sub  = reg_sub_e'(reg_addr[1:0]);

  always_comb begin
    mask_nxt = mask_q;
    if (wr_ent && wr_sub == SUB_CTRL) mask_nxt[wr_idx] = reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '1;
      route_dis <= 1'b0;
      boot_off  <= 1'b0;
      addr_tab  <= '0;
      data_tab  <= '0;
    end else begin
      mask_q <= mask_nxt;
      if (wr_glob) begin
        route_dis <= reg_wdata[0];
        boot_off  <= reg_wdata[1];
      end
      if (wr_ent && wr_sub == SUB_ADDR) addr_tab[wr_idx] <= reg_wdata;
      if (wr_ent && wr_sub == SUB_DATA) data_tab[wr_idx] <= reg_wdata;
    end
  end

  assign rd_addr = addr_tab[rd_idx];
  assign rd_data = data_tab[rd_idx];

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ent && wr_sub == SUB_CTRL) |=> mask_q[$past(wr_idx)] == $past(reg_wdata[0])); // R10

endmodule

// File: rtl/intx_msi_arb.sv
module intx_msi_arb #(
  parameter int NUM_PORTS = 4,
  parameter int WORD_W    = 32,
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int ENTRY_W  = PORT_W + intx_pkg::PIN_W,
  localparam int N        = NUM_PORTS * intx_pkg::PINS_PER_PORT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       set_vec,
  input  logic [N-1:0]       cancel_vec,
  input  logic [WORD_W-1:0]  sel_addr,
  input  logic [WORD_W-1:0]  sel_data,
  output logic [ENTRY_W-1:0] grant_idx,
  input  logic               msi_ready,
  output logic               msi_valid,
  output logic [WORD_W-1:0]  msi_addr,
  output logic [WORD_W-1:0]  msi_data
);
  import intx_pkg::*;

  logic [N-1:0] pend_q;
  logic [N-1:0] pend_nxt;
  logic [N-1:0] grant_vec;
  logic         load;

  assign load      = (|pend_q) && (!msi_valid || msi_ready);
  assign grant_vec = load ? N'(lowest_onehot(MAX_ENTRIES'(pend_q))) : '0;
  assign grant_idx = ENTRY_W'(onehot_index(MAX_ENTRIES'(grant_vec)));
  assign pend_nxt  = (pend_q & ~grant_vec & ~cancel_vec) | set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      msi_valid <= 1'b0;
      msi_addr  <= '0;
      msi_data  <= '0;
    end else begin
      pend_q <= pend_nxt;
      if (load) begin
        msi_valid <= 1'b1;
        msi_addr  <= sel_addr;
        msi_data  <= sel_data;
      end else if (msi_ready) begin
        msi_valid <= 1'b0;
      end
    end
  end

  AST_MSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && !msi_ready) |=> msi_valid && $stable(msi_addr) && $stable(msi_data)); // R8
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec)); // R9
  AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_vec) |-> ((grant_vec - N'(1)) & pend_q) == '0); // R9
  AST_SET_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> (|pend_q) || msi_valid); // R6

endmodule

// File: rtl/intx_legacy_or.sv
module intx_legacy_or #(
  parameter int NUM_PORTS = 4,
  localparam int NPIN     = intx_pkg::PINS_PER_PORT,
  localparam int N        = NUM_PORTS * NPIN
) (
  input  logic [N-1:0]    flag_q,
  input  logic [N-1:0]    mask_q,
  input  logic            fwd_en,
  output logic [NPIN-1:0] legacy_out
);

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic any;
    always_comb begin
      any = 1'b0;
      for (int q = 0; q < NUM_PORTS; q++) begin
        any = any | (flag_q[q*NPIN + p] & mask_q[q*NPIN + p]);
      end
    end
    assign legacy_out[p] = fwd_en & any;
  end

endmodule

// File: rtl/intx_router.sv
module intx_router #(
  parameter int NUM_PORTS = 4,
  parameter int WORD_W    = 32,
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int ENTRY_W  = PORT_W + intx_pkg::PIN_W,
  localparam int N        = NUM_PORTS * intx_pkg::PINS_PER_PORT,
  localparam int RA_W     = ENTRY_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  input  logic [PORT_W-1:0] msg_port,
  input  logic [1:0]        msg_pin,
  input  logic              msg_assert,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic              msi_valid,
  input  logic              msi_ready,
  output logic [WORD_W-1:0] msi_addr,
  output logic [WORD_W-1:0] msi_data,
  output logic [3:0]        legacy_out
);

  logic [N-1:0]       flag_q, flag_nxt;
  logic [N-1:0]       mask_q, mask_nxt;
  logic [N-1:0]       set_vec, cancel_vec;
  logic               route_dis, boot_off, fwd_en;
  logic [ENTRY_W-1:0] grant_idx;
  logic [WORD_W-1:0]  sel_addr, sel_data;

  intx_wire_state #(.NUM_PORTS(NUM_PORTS)) u_wires (
    .clk, .rst_n, .msg_valid, .msg_port, .msg_pin, .msg_assert,
    .flag_q, .flag_nxt
  );

  intx_cfg_regs #(.NUM_PORTS(NUM_PORTS), .WORD_W(WORD_W)) u_cfg (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata,
    .rd_idx(grant_idx), .mask_q, .mask_nxt, .route_dis, .boot_off,
    .rd_addr(sel_addr), .rd_data(sel_data)
  );

  // An entry arms a request when it becomes "raised and unmasked".
  assign set_vec    = flag_nxt & ~mask_nxt & ~(flag_q & ~mask_q);
  assign cancel_vec = mask_nxt;
  assign fwd_en     = !route_dis && !boot_off;

  intx_msi_arb #(.NUM_PORTS(NUM_PORTS), .WORD_W(WORD_W)) u_arb (
    .clk, .rst_n, .set_vec, .cancel_vec, .sel_addr, .sel_data, .grant_idx,
    .msi_ready, .msi_valid, .msi_addr, .msi_data
  );

  intx_legacy_or #(.NUM_PORTS(NUM_PORTS)) u_legacy (
    .flag_q, .mask_q, .fwd_en, .legacy_out
  );

  AST_DROP_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    route_dis |-> legacy_out == 4'b0); // R4
  AST_BOOT_OFF_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    boot_off |-> legacy_out == 4'b0); // R5
  AST_SET_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ($past(set_vec) & mask_q) == '0); // R7

endmodule

// File: tb/intx_router_test.sv
module intx_router_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic [1:0]  msg_port = '0;
  logic [1:0]  msg_pin = '0;
  logic        msg_assert = 1'b0;
  logic        reg_wr = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        msi_valid;
  logic        msi_ready = 1'b0;
  logic [31:0] msi_addr, msi_data;
  logic [3:0]  legacy_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intx_router #(.NUM_PORTS(NP), .WORD_W(32)) uut (
    .clk, .rst_n, .msg_valid, .msg_port, .msg_pin, .msg_assert,
    .reg_wr, .reg_addr, .reg_wdata, .msi_valid, .msi_ready,
    .msi_addr, .msi_data, .legacy_out
  );

  function automatic logic [31:0] ent_msi_addr(int e); return 32'hFEE0_0000 + 32'(e) * 32'h10; endfunction
  function automatic logic [31:0] ent_msi_data(int e); return 32'h0000_4000 + 32'(e); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_msg(int port, int pin, bit raise);
    @(negedge clk);
    msg_valid = 1'b1; msg_port = 2'(port); msg_pin = 2'(pin); msg_assert = raise;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic reg_write(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_mask(int e, bit m);
    reg_write({1'b0, 4'(e), 2'd0}, {31'b0, m});
  endtask

  task automatic set_global(bit rdis, bit boff);
    reg_write(7'h40, {30'b0, boff, rdis});
  endtask

  task automatic expect_msi(string req, int e);
    int waited = 0;
    while (!msi_valid && waited < 10) begin @(negedge clk); waited++; end
    check(req, {31'b0, msi_valid}, 32'd1);
    check(req, msi_addr, ent_msi_addr(e));
    check(req, msi_data, ent_msi_data(e));
    msi_ready = 1'b1;
    @(negedge clk);
    msi_ready = 1'b0;
  endtask

  task automatic expect_no_msi(string req);
    int seen = 0;
    msi_ready = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (msi_valid) seen++;
    end
    msi_ready = 1'b0;
    check(req, 32'(seen), 32'd0);
  endtask

  task automatic t_reset;
    check("R1 msi_valid", {31'b0, msi_valid}, 32'd0);
    check("R1 legacy_out", {28'b0, legacy_out}, 32'd0);
    // masks set by reset: a raise goes to legacy, not MSI
    send_msg(3, 3, 1'b1);
    check("R1 masked after reset", {28'b0, legacy_out}, 32'h8);
    send_msg(3, 3, 1'b0);
    expect_no_msi("R1 no MSI from masked");
  endtask

  task automatic t_shared_line;
    send_msg(0, 1, 1'b1);
    check("R2 R3 one contributor", {28'b0, legacy_out}, 32'h2);
    send_msg(2, 1, 1'b1);
    send_msg(0, 1, 1'b0);
    check("R3 still held by port2", {28'b0, legacy_out}, 32'h2);
    send_msg(2, 1, 1'b0);
    check("R3 all dropped", {28'b0, legacy_out}, 32'h0);
  endtask

  task automatic t_globals;
    send_msg(1, 2, 1'b1);            // entry 6, masked
    check("R3 INTC forwarded", {28'b0, legacy_out}, 32'h4);
    set_global(1'b1, 1'b0);
    check("R4 route disable drops", {28'b0, legacy_out}, 32'h0);
    expect_no_msi("R4 no MSI while dropped");
    set_global(1'b0, 1'b0);
    check("R4 restored", {28'b0, legacy_out}, 32'h4);
    set_global(1'b0, 1'b1);
    check("R5 boot-off 1 stops", {28'b0, legacy_out}, 32'h0);
    set_global(1'b0, 1'b0);
    check("R5 boot-off 0 allows", {28'b0, legacy_out}, 32'h4);
  endtask

  task automatic t_msi_handover;
    // entry 6 still raised and masked
    set_mask(6, 1'b0);
    check("R6 unmasked not legacy", {28'b0, legacy_out}, 32'h0);
    expect_msi("R7 unmask while raised", 6);
    send_msg(1, 2, 1'b1);
    expect_no_msi("R6 repeated raise");
    send_msg(1, 2, 1'b0);
    send_msg(1, 2, 1'b1);
    expect_msi("R6 fresh rise", 6);
    set_mask(6, 1'b1);
    check("R7 mask moves to legacy", {28'b0, legacy_out}, 32'h4);
    send_msg(1, 2, 1'b0);
    check("R2 drop clears", {28'b0, legacy_out}, 32'h0);
  endtask

  task automatic t_priority;
    logic [31:0] a0;
    set_mask(9, 1'b0); set_mask(5, 1'b0); set_mask(2, 1'b0);
    send_msg(2, 1, 1'b1);            // entry 9, reaches output first
    send_msg(1, 1, 1'b1);            // entry 5
    send_msg(0, 2, 1'b1);            // entry 2
    a0 = msi_addr;
    repeat (3) @(negedge clk);
    check("R8 valid held", {31'b0, msi_valid}, 32'd1);
    check("R8 addr held", msi_addr, a0);
    expect_msi("R9 first (occupied)", 9);
    expect_msi("R9 lowest next", 2);
    expect_msi("R9 then higher", 5);
    send_msg(2, 1, 1'b0); send_msg(1, 1, 1'b0); send_msg(0, 2, 1'b0);
  endtask

  task automatic t_cancel;
    set_mask(10, 1'b0);
    send_msg(2, 1, 1'b1);            // entry 9 occupies output
    send_msg(2, 2, 1'b1);            // entry 10 pending
    set_mask(10, 1'b1);              // withdraw
    check("R7 masked pending on legacy", {28'b0, legacy_out}, 32'h4);
    expect_msi("R7 busy entry served", 9);
    expect_no_msi("R7 cancelled request");
    send_msg(2, 1, 1'b0); send_msg(2, 2, 1'b0);
  endtask

  task automatic t_rsvd_sub;
    // sub 3 must not alter entry 7's mask: raise stays on legacy
    reg_write({1'b0, 4'd7, 2'd3}, 32'h0);
    send_msg(1, 3, 1'b1);
    check("R10 reserved sub ignored", {28'b0, legacy_out}, 32'h8);
    expect_no_msi("R10 no MSI");
    send_msg(1, 3, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    for (int e = 0; e < NP*4; e++) begin
      reg_write({1'b0, 4'(e), 2'd1}, ent_msi_addr(e));
      reg_write({1'b0, 4'(e), 2'd2}, ent_msi_data(e));
    end
    t_shared_line();
    t_globals();
    t_msi_handover();
    t_priority();
    t_cancel();
    t_rsvd_sub();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule